// File: doc/BRIEF.md
# Message-Signalled Interrupt File with Indirect Register Access

This block is the per-hart receiver for message-signalled interrupts. Each incoming message carries an identity number. A valid number sets that identity's pending bit. A separate enable bit for each identity decides whether a pending identity may interrupt. The block drives one external interrupt request line to the hart. The line is raised when delivery is switched on and at least one identity is pending, enabled, and allowed through by the priority threshold.

Software does not see a flat register map. It first writes a selector value. It then works on the selected register through a data port. The data port supports a plain write, a bit-set write and a bit-clear write, so a group of enable or pending bits can be changed in one access without reading the register first.

A claim port shows the eligible identity with the highest priority, where a lower number means higher priority. A claim write takes that identity off the pending array. The parameters set the width of the data port (`XLEN`, 32 or 64) and the number of implemented identities (`NUM_IDS`, 63 to 2047).

Top module: `msi_intfile`

## Requirements
- R1: After reset every pending and enable bit, the delivery enable and the threshold are zero, `irq` is low and `claim_rdata` is zero.
- R2: The enable array is reached at selectors 0xC0 and up, and the pending array at 0x80 and up. With a 64-bit port, array register k sits at selector base+2k and covers identities 64k to 64k+63. Odd array selectors read zero and ignore writes. Selectors that are not mapped read zero.
- R3: `dat_op` encodes 0 = no access, 1 = plain write, 2 = bit-set (old OR data), 3 = bit-clear (old AND NOT data). The operation applies to the register selected by the selector value held before that cycle.
- R4: Bit 0 of the first array registers (identity 0) reads zero and ignores writes. Bits above `NUM_IDS`, including whole array registers beyond the last implemented one, read zero.
- R5: A message with `msi_valid` high and `msi_data` between 1 and `NUM_IDS` sets pending bit `msi_data` at the next clock edge. Any other value is dropped and leaves the pending array unchanged.
- R6: The delivery enable is bit 0 at selector 0x70. `irq` can be high only while it is 1.
- R7: The threshold is at selector 0x72. A value of 0 lets every identity through. A nonzero value T lets only identities below T through, so T = 1 blocks all identities.
- R8: `claim_rdata` gives the lowest-numbered identity that is pending, enabled and allowed by the threshold. The identity appears in bits 10:0 and again in bits 26:16, and all other bits are zero. The value is 0 when no identity is eligible, and it does not depend on the delivery enable.
- R9: A pulse on `claim_we` clears the pending bit of the identity shown on `claim_rdata` in that cycle.
- R10: If a message for identity i arrives in the same cycle as a claim write or a software clear of pending bit i, the pending bit ends up set.
- R11: Software can set pending bits through the data port at 0x80 and up, and those bits interrupt the same way as message arrivals.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_we | input | 1 | Load the selector register |
| sel_wdata | input | SELW | New selector value |
| dat_op | input | 2 | Data port operation: none, write, set, clear |
| dat_wdata | input | XLEN | Data port write operand |
| dat_rdata | output | XLEN | Current content of the selected register |
| msi_valid | input | 1 | Incoming message write strobe |
| msi_data | input | 32 | Identity number carried by the message |
| claim_we | input | 1 | Claim the identity currently shown |
| claim_rdata | output | 32 | Top eligible identity, in two fields |
| irq | output | 1 | External interrupt request to the hart |

## Verification
Three paths can write the pending array in the same cycle: an incoming message, a claim write, and a software clear through the data port. The bench drives a message for the identity being claimed in the same cycle as the claim write. It then drives a message together with a data-port bit-clear of the same pending bit. In both cases it reads the pending register back through the data port and expects the bit to still be set. A further clear without a message must remove the bit and drop the request.

// File: rtl/msi_intfile.sv
module msi_intfile #(
  parameter int XLEN    = 64,
  parameter int NUM_IDS = 127,
  parameter int SELW    = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sel_we,
  input  logic [SELW-1:0] sel_wdata,
  input  logic [1:0]      dat_op,
  input  logic [XLEN-1:0] dat_wdata,
  output logic [XLEN-1:0] dat_rdata,
  input  logic            msi_valid,
  input  logic [31:0]     msi_data,
  input  logic            claim_we,
  output logic [31:0]     claim_rdata,
  output logic            irq
);

  localparam int IDW  = $clog2(NUM_IDS + 1);
  localparam int NREG = (NUM_IDS + XLEN) / XLEN;
  localparam int NB   = NREG * XLEN;
  localparam int STEP = XLEN / 32;

  localparam logic [1:0] OP_WR  = 2'd1;
  localparam logic [1:0] OP_SET = 2'd2;
  localparam logic [1:0] OP_CLR = 2'd3;

  function automatic logic [NB-1:0] impl_mask();
    logic [NB-1:0] m;
    for (int i = 0; i < NB; i++) m[i] = (i >= 1) && (i <= NUM_IDS);
    return m;
  endfunction

  localparam logic [NB-1:0] IMPL = impl_mask();

  function automatic logic [XLEN-1:0] apply_op(logic [1:0] op, logic [XLEN-1:0] old,
                                              logic [XLEN-1:0] d);
    case (op)
      OP_WR:   return d;
      OP_SET:  return old | d;
      OP_CLR:  return old & ~d;
      default: return old;
    endcase
  endfunction

  logic [SELW-1:0] sel_q;
  logic            del_en;
  logic [IDW-1:0]  thr;
  logic [NB-1:0]   pend, en;

  wire is_del  = sel_q == SELW'('h70);
  wire is_thr  = sel_q == SELW'('h72);
  wire is_parr = sel_q[SELW-1:6] == (SELW-6)'(2);
  wire is_earr = sel_q[SELW-1:6] == (SELW-6)'(3);

  int  word;
  logic aligned, arr_hit;
  logic [XLEN-1:0] p_word, e_word;

  always_comb begin
    word    = int'(sel_q[5:0]) / STEP;
    aligned = (int'(sel_q[5:0]) % STEP) == 0;
    arr_hit = (is_parr || is_earr) && aligned && (word < NREG);
    p_word  = '0;
    e_word  = '0;
    for (int j = 0; j < NREG; j++) begin
      if (word == j) begin
        p_word = pend[j*XLEN +: XLEN];
        e_word = en[j*XLEN +: XLEN];
      end
    end
  end

  always_comb begin
    if (is_del)       dat_rdata = XLEN'(del_en);
    else if (is_thr)  dat_rdata = XLEN'(thr);
    else if (arr_hit) dat_rdata = is_parr ? p_word : e_word;
    else              dat_rdata = '0;
  end

  logic [NB-1:0] elig;
  logic [IDW-1:0] top_id;

  always_comb begin
    for (int i = 0; i < NB; i++)
      elig[i] = pend[i] & en[i] & ((thr == '0) || (i < int'(thr)));
    top_id = '0;
    for (int i = NUM_IDS; i >= 1; i--)
      if (elig[i]) top_id = IDW'(i);
  end

  wire [10:0] tid11 = 11'(top_id);
  assign claim_rdata = {5'b0, tid11, 5'b0, tid11};
  assign irq         = del_en & (top_id != '0);

  wire msi_ok = msi_valid && (msi_data >= 32'd1) && (msi_data <= 32'(NUM_IDS));

  logic [NB-1:0] pend_sw, en_sw, clr_m, set_m, pend_d, en_d;

  always_comb begin
    pend_sw = pend;
    en_sw   = en;
    for (int j = 0; j < NREG; j++) begin
      if (arr_hit && word == j && dat_op != 2'd0) begin
        if (is_parr) pend_sw[j*XLEN +: XLEN] = apply_op(dat_op, pend[j*XLEN +: XLEN], dat_wdata);
        else         en_sw[j*XLEN +: XLEN]   = apply_op(dat_op, en[j*XLEN +: XLEN], dat_wdata);
      end
    end
    clr_m = '0;
    if (claim_we && top_id != '0) clr_m[top_id] = 1'b1;
    set_m = '0;
    if (msi_ok) set_m[msi_data[IDW-1:0]] = 1'b1;
    pend_d = ((pend_sw & ~clr_m) | set_m) & IMPL;
    en_d   = en_sw & IMPL;
  end

  logic [XLEN-1:0] del_new, thr_new;
  assign del_new = apply_op(dat_op, XLEN'(del_en), dat_wdata);
  assign thr_new = apply_op(dat_op, XLEN'(thr), dat_wdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      del_en <= 1'b0;
      thr    <= '0;
      pend   <= '0;
      en     <= '0;
    end else begin
      if (sel_we) sel_q <= sel_wdata;
      if (is_del && dat_op != 2'd0) del_en <= del_new[0];
      if (is_thr && dat_op != 2'd0) thr    <= thr_new[IDW-1:0];
      pend <= pend_d;
      en   <= en_d;
    end
  end

  // R5 and R10: an accepted message always leaves its bit set
  p_msi_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    msi_ok |=> pend[$past(msi_data[IDW-1:0])]);

  p_msi_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (msi_valid && !msi_ok && dat_op == 2'd0 && !claim_we) |=> $stable(pend));

  p_claim_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (claim_we && top_id != '0 && !msi_valid && dat_op == 2'd0) |=> !pend[$past(top_id)]);

  p_no_deliv_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !del_en |-> !irq);

  p_thr_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (thr == IDW'(1)) |-> (claim_rdata == 32'd0));

endmodule

// File: tb/tb_msi_intfile.sv
module tb_msi_intfile;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 64;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            sel_we = 1'b0;
  logic [11:0]     sel_wdata = '0;
  logic [1:0]      dat_op = '0;
  logic [XLEN-1:0] dat_wdata = '0;
  logic [XLEN-1:0] dat_rdata;
  logic            msi_valid = 1'b0;
  logic [31:0]     msi_data = '0;
  logic            claim_we = 1'b0;
  logic [31:0]     claim_rdata;
  logic            irq;

  int n_chk = 0;
  int n_fail = 0;

  msi_intfile dut (
    .clk(clk), .rst_n(rst_n), .sel_we(sel_we), .sel_wdata(sel_wdata),
    .dat_op(dat_op), .dat_wdata(dat_wdata), .dat_rdata(dat_rdata),
    .msi_valid(msi_valid), .msi_data(msi_data), .claim_we(claim_we),
    .claim_rdata(claim_rdata), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic cycle();
    @(posedge clk); #1;
    sel_we = 1'b0; dat_op = 2'd0; msi_valid = 1'b0; claim_we = 1'b0;
  endtask

  task automatic select(logic [11:0] s);
    sel_we = 1'b1; sel_wdata = s; cycle();
  endtask

  task automatic do_op(logic [11:0] s, logic [1:0] op, logic [63:0] d);
    select(s);
    dat_op = op; dat_wdata = d; cycle();
  endtask

  task automatic rd(logic [11:0] s, output logic [63:0] v);
    select(s);
    v = dat_rdata;
  endtask

  task automatic msi(logic [31:0] id);
    msi_valid = 1'b1; msi_data = id; cycle();
  endtask

  task automatic t_reset();
    logic [63:0] v;
    check("R1 irq", 64'(irq), 64'd0);
    check("R1 claim", 64'(claim_rdata), 64'd0);
    rd(12'h0C0, v); check("R1 enable0", v, 64'd0);
    rd(12'h070, v); check("R1 delivery", v, 64'd0);
  endtask

  task automatic t_rw();
    logic [63:0] v;
    do_op(12'h0C0, 2'd1, 64'hA5A5_0000_1234_5679);
    rd(12'h0C0, v); check("R2/R4 enable0 write, id0 masked", v, 64'hA5A5_0000_1234_5678);
    do_op(12'h0C1, 2'd1, '1);
    rd(12'h0C1, v); check("R2 odd select reads zero", v, 64'd0);
    rd(12'h0C0, v); check("R2 odd select write ignored", v, 64'hA5A5_0000_1234_5678);
    do_op(12'h0C2, 2'd1, '1);
    rd(12'h0C2, v); check("R2 enable1 full", v, '1);
    do_op(12'h0C4, 2'd1, '1);
    rd(12'h0C4, v); check("R4 unimplemented word", v, 64'd0);
    do_op(12'h080, 2'd1, 64'd1);
    rd(12'h080, v); check("R4 pending id0", v, 64'd0);
    rd(12'h0A0, v); check("R2 unmapped select", v, 64'd0);
  endtask

  task automatic t_setclr();
    logic [63:0] v;
    do_op(12'h0C0, 2'd1, 64'd0);
    do_op(12'h0C0, 2'd2, 64'hF0);
    rd(12'h0C0, v); check("R3 set", v, 64'hF0);
    do_op(12'h0C0, 2'd2, 64'hF00);
    rd(12'h0C0, v); check("R3 set keeps old", v, 64'hFF0);
    do_op(12'h0C0, 2'd3, 64'h30);
    rd(12'h0C0, v); check("R3 clear", v, 64'hFC0);
    do_op(12'h0C0, 2'd1, '1);
    rd(12'h0C0, v); check("R3 write all, id0 zero", v, 64'hFFFF_FFFF_FFFF_FFFE);
  endtask

  task automatic t_msi();
    logic [63:0] v;
    msi(32'd5);
    rd(12'h080, v); check("R5 msi 5 pending", v, 64'h20);
    msi(32'd128); msi(32'd0); msi(32'h0001_0005);
    rd(12'h080, v); check("R5 dropped low word", v, 64'h20);
    rd(12'h082, v); check("R5 dropped high word", v, 64'd0);
  endtask

  task automatic t_deliv();
    logic [63:0] v;
    check("R6 irq off while delivery off", 64'(irq), 64'd0);
    do_op(12'h070, 2'd1, 64'd1);
    check("R6 irq on", 64'(irq), 64'd1);
    rd(12'h070, v); check("R6 delivery readback", v, 64'd1);
    do_op(12'h070, 2'd3, 64'd1);
    check("R6 irq off after clear", 64'(irq), 64'd0);
    do_op(12'h070, 2'd2, 64'd1);
    check("R6 irq on after set", 64'(irq), 64'd1);
  endtask

  task automatic t_thr();
    logic [63:0] v;
    do_op(12'h072, 2'd1, 64'd5);
    check("R7 thr 5 blocks id 5", 64'(irq), 64'd0);
    check("R7 thr 5 claim", 64'(claim_rdata), 64'd0);
    rd(12'h072, v); check("R7 thr readback", v, 64'd5);
    do_op(12'h072, 2'd1, 64'd6);
    check("R7 thr 6 passes id 5", 64'(irq), 64'd1);
    do_op(12'h072, 2'd1, 64'd1);
    check("R7 thr 1 blocks all", 64'(irq), 64'd0);
    do_op(12'h072, 2'd1, 64'd0);
    check("R7 thr 0 no limit", 64'(irq), 64'd1);
  endtask

  task automatic t_prio();
    logic [63:0] v;
    msi(32'd70);
    check("R8 claim lowest", 64'(claim_rdata), 64'h0005_0005);
    claim_we = 1'b1; cycle();
    check("R9 claim next", 64'(claim_rdata), 64'h0046_0046);
    rd(12'h080, v); check("R9 pending 5 cleared", v, 64'd0);
    rd(12'h082, v); check("R9 pending 70 kept", v, 64'h40);
  endtask

  task automatic t_race();
    logic [63:0] v;
    claim_we = 1'b1; msi_valid = 1'b1; msi_data = 32'd70; cycle();
    rd(12'h082, v); check("R10 msi beats claim", v, 64'h40);
    check("R10 claim still 70", 64'(claim_rdata), 64'h0046_0046);
    select(12'h082);
    dat_op = 2'd3; dat_wdata = 64'h40; msi_valid = 1'b1; msi_data = 32'd70; cycle();
    rd(12'h082, v); check("R10 msi beats sw clear", v, 64'h40);
    do_op(12'h082, 2'd3, 64'h40);
    rd(12'h082, v); check("R10 clear alone", v, 64'd0);
    check("R10 irq drops", 64'(irq), 64'd0);
  endtask

  task automatic t_swpend();
    do_op(12'h080, 2'd2, 64'h8);
    check("R11 sw pending claim", 64'(claim_rdata), 64'h0003_0003);
    check("R11 sw pending irq", 64'(irq), 64'd1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_rw();
    t_setclr();
    t_msi();
    t_deliv();
    t_thr();
    t_prio();
    t_race();
    t_swpend();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule